// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Engine

The block shifts characters out of a serial port in one of two ways. In asynchronous mode it sends each character framed by a low start bit and a high stop bit, least significant bit first, with one bit per tick from an external baud-rate generator. The line idles high. In synchronous mode it sends the bare data bits on a separate data pin. As clock master it drives the serial clock itself from the fast baud tick. As clock slave it follows a clock arriving on the clock pin, after a synchronizer.

Characters are 8 or 9 bits wide. The ninth bit is taken from a control-register bit at the moment the data is written, so it can carry a parity bit. A one-entry holding register sits in front of the shift register, so software can queue the next character while the current one is still going out. A status bit reports when the shift register is empty. A global port enable gates both output enables and the start of any character. In synchronous mode a pending receive request keeps the transmitter from starting.

Top module: `usart_tx_engine`

## Requirements
- R1: After reset the control readback is 0x40: every writable control bit is 0 and the empty status bit is 1. Both output enables are 0 and both serial outputs are 1.
- R2: The writable control bits read back as written. They are bit 0 synchronous mode, bit 1 clock master, bit 2 nine-bit characters, bit 3 transmit enable, bit 4 high-speed tick and bit 7 ninth data bit. Bit 5 always reads 0, and bit 6 reads the empty status whatever value is written to it.
- R3: In asynchronous mode a loaded character drives `txck_o` with these bits in order: a start bit of 0, the data bits LSB first, then a stop bit of 1. The start bit appears on the clock edge that loads the character, and each following bit appears on an edge where the selected tick is high. The line is 1 whenever the shift register is empty.
- R4: In asynchronous mode, bit 4 set selects `tick_hi` as the bit tick and bit 4 clear selects `tick_lo`. In synchronous mode bit 4 has no effect.
- R5: With bit 2 set a character carries 9 data bits. The ninth bit is the value of control bit 7 at the edge that captures the data write. It is sent after data bit 7, in both modes.
- R6: In synchronous master mode `txck_o` idles at 1 and toggles on each edge with `tick_hi` high while a character is in progress. `dt_o` changes only on the edge that takes the clock from 1 to 0, where it presents the next data bit. A character of 8 or 9 bits ends on the clock's last rising edge, and no start or stop bit is sent.
- R7: In synchronous slave mode `txck_oe` is 0. The clock on `ck_pin_i` passes through `SYNC_STAGES` flops, and each falling edge detected there updates `dt_o` with the next bit. The next rising edge then retires that bit.
- R8: In asynchronous mode the clock-master bit has no effect on any output.
- R9: A character starts only while transmit enable is 1. In synchronous mode a high `rx_req` also holds off the start. In asynchronous mode `rx_req` has no effect.
- R10: While `port_en` is 0 both output enables are 0 and no character starts. With `port_en` 1, `txck_oe` is 1 except in synchronous slave mode, and `dt_oe` is 1 in synchronous mode only.
- R11: A data write while the shift register is busy is held. It is loaded on the first edge at which the shift register is empty and the start conditions hold. A write in that same cycle replaces the held value after the old one is taken.
- R12: Status bit 6 is 0 from the loading edge until the edge that retires the last bit of the character, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Global serial port enable |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control readback with empty status |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | DATA_W | Character data |
| rx_req | input | 1 | Receive request, holds off synchronous transmit |
| tick_hi | input | 1 | Fast baud tick |
| tick_lo | input | 1 | Slow baud tick |
| ck_pin_i | input | 1 | External clock input for slave mode |
| txck_o | output | 1 | Asynchronous data or synchronous clock output |
| txck_oe | output | 1 | Output enable for txck_o |
| dt_o | output | 1 | Synchronous data output |
| dt_oe | output | 1 | Output enable for dt_o |

## Verification
A data write is captured on its edge and loaded on the next edge, so the empty status falls two edges after the write strobe. In asynchronous mode the start bit shows in that same cycle, and each later bit moves one edge after a selected tick. In slave mode a pin edge is acted on `SYNC_STAGES`+1 edges after it is sampled. The bench keeps a behavioural model that advances on the same edge as the design and checks all outputs 1 ns after every rising edge, so each due cycle is checked exactly.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;
   localparam int CTL_W   = 8;
   localparam int B_SYNC  = 0;
   localparam int B_MAST  = 1;
   localparam int B_NINE  = 2;
   localparam int B_TXEN  = 3;
   localparam int B_HISPD = 4;
   localparam int B_RSVD  = 5;
   localparam int B_EMPTY = 6;
   localparam int B_D9    = 7;

   typedef struct packed {
      logic d9;
      logic hispd;
      logic txen;
      logic nine;
      logic master;
      logic sync;
   } cfg_t;
endpackage

// File: rtl/usart_tx_ctlreg.sv
module usart_tx_ctlreg
   import usart_tx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             empty,
   output cfg_t             cfg,
   output logic [CTL_W-1:0] rdata
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[B_RSVD], wdata[B_EMPTY]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr) begin
         cfg.d9     <= wdata[B_D9];
         cfg.hispd  <= wdata[B_HISPD];
         cfg.txen   <= wdata[B_TXEN];
         cfg.nine   <= wdata[B_NINE];
         cfg.master <= wdata[B_MAST];
         cfg.sync   <= wdata[B_SYNC];
      end
   end

   always_comb begin
      rdata          = '0;
      rdata[B_SYNC]  = cfg.sync;
      rdata[B_MAST]  = cfg.master;
      rdata[B_NINE]  = cfg.nine;
      rdata[B_TXEN]  = cfg.txen;
      rdata[B_HISPD] = cfg.hispd;
      rdata[B_EMPTY] = empty;
      rdata[B_D9]    = cfg.d9;
   end
endmodule

// File: rtl/usart_tx_holdreg.sv
module usart_tx_holdreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              d9,
   input  logic              take,
   output logic              full,
   output logic [DATA_W:0]   data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (wr) begin
         full <= 1'b1;
         data <= {d9, wdata};
      end else if (take) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/usart_tx_clkevt.sv
module usart_tx_clkevt #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic sync,
   input  logic master,
   input  logic tick_hi,
   input  logic ext_clk,
   output logic fall_ev,
   output logic rise_ev,
   output logic ck_q
);
   logic [SYNC_STAGES-1:0] sc;
   logic                   prev;
   logic                   cur;

   assign cur = sc[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc   <= '1;
         prev <= 1'b1;
      end else begin
         sc   <= {sc[SYNC_STAGES-2:0], ext_clk};
         prev <= cur;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !busy)
         ck_q <= 1'b1;
      else if (sync && master && tick_hi)
         ck_q <= ~ck_q;
   end

   logic m_act, s_act;
   assign m_act = busy && sync && master && tick_hi;
   assign s_act = busy && sync && !master;

   assign fall_ev = (m_act && ck_q) || (s_act && prev && !cur);
   assign rise_ev = (m_act && !ck_q) || (s_act && !prev && cur);
endmodule

// File: rtl/usart_tx_shifter.sv
module usart_tx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            sync,
   input  logic            nine,
   input  logic [DATA_W:0] data,
   input  logic            adv,
   input  logic            fall_ev,
   input  logic            rise_ev,
   output logic            busy,
   output logic            line,
   output logic            dt_q
);
   localparam int FRAME_W = DATA_W + 3;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] C_S8 = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] C_S9 = CNT_W'(DATA_W + 1);
   localparam logic [CNT_W-1:0] C_A8 = CNT_W'(DATA_W + 2);
   localparam logic [CNT_W-1:0] C_A9 = CNT_W'(DATA_W + 3);

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;
   logic               half;
   logic               step;

   assign step = busy && (sync ? (rise_ev && half) : adv);
   assign line = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         cnt   <= '0;
         half  <= 1'b0;
         dt_q  <= 1'b1;
      end else if (load) begin
         busy <= 1'b1;
         half <= 1'b0;
         if (sync) begin
            shreg <= {2'b11, data};
            cnt   <= nine ? C_S9 : C_S8;
         end else begin
            shreg <= nine ? {1'b1, data, 1'b0} : {2'b11, data[DATA_W-1:0], 1'b0};
            cnt   <= nine ? C_A9 : C_A8;
         end
      end else if (busy) begin
         if (sync && fall_ev) begin
            dt_q <= shreg[0];
            half <= 1'b1;
         end
         if (step) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            cnt   <= cnt - 1'b1;
            half  <= 1'b0;
            if (cnt == CNT_W'(1))
               busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/usart_tx_engine.sv
module usart_tx_engine
   import usart_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   output logic [7:0]        ctl_rdata,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   input  logic              rx_req,
   input  logic              tick_hi,
   input  logic              tick_lo,
   input  logic              ck_pin_i,
   output logic              txck_o,
   output logic              txck_oe,
   output logic              dt_o,
   output logic              dt_oe
);
   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("usart_tx_engine: DATA_W must be within 5..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("usart_tx_engine: SYNC_STAGES must be at least 2");
   end
   if (CTL_W != 8) begin : g_bad_ctl
      $error("usart_tx_engine: control register must be 8 bits");
   end

   cfg_t            cfg;
   logic            busy, line, dt_q, ck_q;
   logic            fall_ev, rise_ev;
   logic            hold_full, load, txen_eff, adv;
   logic [DATA_W:0] hold_data;

   assign txen_eff = cfg.txen && !(cfg.sync && rx_req);
   assign load     = hold_full && !busy && txen_eff && port_en;
   assign adv      = cfg.hispd ? tick_hi : tick_lo;

   usart_tx_ctlreg u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .empty(!busy), .cfg(cfg), .rdata(ctl_rdata)
   );

   usart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr(dat_wr), .wdata(dat_wdata),
      .d9(cfg.d9), .take(load), .full(hold_full), .data(hold_data)
   );

   usart_tx_clkevt #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
      .clk(clk), .rst_n(rst_n), .busy(busy), .sync(cfg.sync),
      .master(cfg.master), .tick_hi(tick_hi), .ext_clk(ck_pin_i),
      .fall_ev(fall_ev), .rise_ev(rise_ev), .ck_q(ck_q)
   );

   usart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .sync(cfg.sync),
      .nine(cfg.nine), .data(hold_data), .adv(adv),
      .fall_ev(fall_ev), .rise_ev(rise_ev),
      .busy(busy), .line(line), .dt_q(dt_q)
   );

   assign txck_o  = cfg.sync ? ck_q : line;
   assign txck_oe = port_en && !(cfg.sync && !cfg.master);
   assign dt_o    = dt_q;
   assign dt_oe   = port_en && cfg.sync;
endmodule

// File: rtl/usart_tx_engine_chk.sv
module usart_tx_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       port_en,
   input logic       rx_req,
   input logic [7:0] ctl_rdata,
   input logic       txck_o,
   input logic       txck_oe,
   input logic       dt_o,
   input logic       dt_oe
);
   // R10
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> (!txck_oe && !dt_oe));

   // R10
   no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_en && ctl_rdata[6]) |=> ctl_rdata[6]);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[5] == 1'b0);

   // R3
   async_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[6] && !ctl_rdata[0]) |-> txck_o);

   // R6
   master_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[6] && ctl_rdata[0] && ctl_rdata[1]) |-> txck_o);

   // R6
   master_dt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[0] && ctl_rdata[1] && !$stable(dt_o)) |-> $fell(txck_o));

   // R9
   txen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[3] && ctl_rdata[6]) |=> ctl_rdata[6]);

   // R9
   rxreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[0] && rx_req && ctl_rdata[6]) |=> ctl_rdata[6]);
endmodule

bind usart_tx_engine usart_tx_engine_chk chk_i (
   .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_req(rx_req),
   .ctl_rdata(ctl_rdata), .txck_o(txck_o), .txck_oe(txck_oe),
   .dt_o(dt_o), .dt_oe(dt_oe)
);

// File: tb/usart_tx_engine_tb_top.sv
`timescale 1ns/1ps
module usart_tx_engine_tb_top;
   localparam int DW = 8;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic port_en = 1'b0, ctl_wr = 1'b0, dat_wr = 1'b0, rx_req = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [DW-1:0] dat_wdata = '0;
   logic tick_hi = 1'b0, tick_lo = 1'b0, ck_pin_i = 1'b1;
   logic [7:0] ctl_rdata;
   logic txck_o, txck_oe, dt_o, dt_oe;

   int checks = 0, errors = 0;
   string cur_req = "R1";
   bit slave_run = 0;
   int tcnt = 0;

   always #2 clk = ~clk;

   usart_tx_engine #(.DATA_W(DW), .SYNC_STAGES(SS)) dut_i (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .dat_wr(dat_wr),
      .dat_wdata(dat_wdata), .rx_req(rx_req), .tick_hi(tick_hi),
      .tick_lo(tick_lo), .ck_pin_i(ck_pin_i), .txck_o(txck_o),
      .txck_oe(txck_oe), .dt_o(dt_o), .dt_oe(dt_oe)
   );

   // tick and external clock generation
   always @(negedge clk) begin
      tcnt++;
      tick_hi <= (tcnt % 3 == 0);
      tick_lo <= (tcnt % 7 == 0);
      if (slave_run && (tcnt % 5 == 0)) ck_pin_i <= ~ck_pin_i;
      else if (!slave_run) ck_pin_i <= 1'b1;
   end

   // behavioural reference model
   logic [7:0] m_ctl;
   bit m_hfull, m_busy, m_ck, m_dt, m_half, m_prev;
   int m_hdata;
   bit mq[$];
   bit m_sh[SS];

   always @(posedge clk) begin
      bit o_busy, o_ck, sy, ma, cur, fall, rise, ld, ten, adv;
      if (!rst_n) begin
         m_ctl = 0; m_hfull = 0; m_busy = 0; m_ck = 1; m_dt = 1;
         m_half = 0; m_prev = 1; m_hdata = 0; mq.delete();
         for (int i = 0; i < SS; i++) m_sh[i] = 1;
      end else begin
         o_busy = m_busy; o_ck = m_ck;
         sy = m_ctl[0]; ma = m_ctl[1];
         cur = m_sh[SS-1];
         fall = 0; rise = 0;
         if (o_busy && sy && ma && tick_hi) begin fall = o_ck; rise = !o_ck; end
         if (o_busy && sy && !ma) begin fall = m_prev && !cur; rise = !m_prev && cur; end
         ten = m_ctl[3] && !(sy && rx_req);
         ld = m_hfull && !o_busy && ten && port_en;
         adv = m_ctl[4] ? tick_hi : tick_lo;
         if (ld) begin
            mq.delete();
            if (!sy) mq.push_back(0);
            for (int i = 0; i < DW; i++) mq.push_back(m_hdata[i]);
            if (m_ctl[2]) mq.push_back(m_hdata[DW]);
            if (!sy) mq.push_back(1);
            m_busy = 1; m_half = 0;
         end else if (o_busy) begin
            if (!sy) begin
               if (adv) void'(mq.pop_front());
            end else begin
               if (fall) begin m_dt = mq[0]; m_half = 1; end
               else if (rise && m_half) begin void'(mq.pop_front()); m_half = 0; end
            end
            if (mq.size() == 0) m_busy = 0;
         end
         if (!o_busy) m_ck = 1;
         else if (sy && ma && tick_hi) m_ck = !o_ck;
         if (dat_wr) begin m_hfull = 1; m_hdata = {m_ctl[7], dat_wdata}; end
         else if (ld) m_hfull = 0;
         if (ctl_wr) m_ctl = ctl_wdata & 8'h9F;
         m_prev = cur;
         for (int i = SS-1; i > 0; i--) m_sh[i] = m_sh[i-1];
         m_sh[0] = ck_pin_i;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, 1 ns after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         bit line, sy;
         sy = m_ctl[0];
         line = m_busy ? mq[0] : 1'b1;
         chk(cur_req, "txck_o", txck_o, sy ? m_ck : line);
         chk(cur_req, "dt_o", dt_o, m_dt);
         chk("R10", "txck_oe", txck_oe, port_en && !(sy && !m_ctl[1]));
         chk("R10", "dt_oe", dt_oe, port_en && sy);
         chk("R12", "ctl_rdata", ctl_rdata, m_ctl | (m_busy ? 8'h00 : 8'h40));
      end
   end

   task automatic wr_ctl(logic [7:0] v);
      @(negedge clk); ctl_wr = 1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 0;
   endtask

   task automatic wr_dat(logic [DW-1:0] v);
      @(negedge clk); dat_wr = 1; dat_wdata = v;
      @(negedge clk); dat_wr = 0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (m_busy || m_hfull);
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired act 0 exp 1");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "rdata", ctl_rdata, 8'h40);
      chk("R1", "oe", {txck_oe, dt_oe}, 0);
      chk("R1", "outs", {txck_o, dt_o}, 2'b11);

      // R2 readback, reserved bit and read-only status
      cur_req = "R2";
      wr_ctl(8'hFF);
      chk("R2", "rdata all", ctl_rdata, 8'hDF);
      wr_ctl(8'h00);
      chk("R2", "rdata clr", ctl_rdata, 8'h40);

      port_en = 1;
      // R3 async 8-bit on slow tick
      cur_req = "R3";
      wr_ctl(8'h08); wr_dat(8'hA5); wait_idle();
      // R4 async fast tick
      cur_req = "R4";
      wr_ctl(8'h18); wr_dat(8'h3C); wait_idle();
      // R5 nine-bit async, ninth bit 1 then 0
      cur_req = "R5";
      wr_ctl(8'h8C); wr_dat(8'h5A); wait_idle();
      wr_ctl(8'h0C); wr_dat(8'hFF); wait_idle();
      // R11 holding register: second write while busy
      cur_req = "R11";
      wr_ctl(8'h18); wr_dat(8'h81);
      repeat (5) @(negedge clk);
      chk("R11", "status busy", ctl_rdata[6], 0);
      wr_dat(8'h7E); wait_idle();
      // R8 master bit ignored in async
      cur_req = "R8";
      wr_ctl(8'h1A); wr_dat(8'hC3); wait_idle();
      // R9 transmit disabled then enabled
      cur_req = "R9";
      wr_ctl(8'h10); wr_dat(8'h99);
      repeat (30) @(negedge clk);
      chk("R9", "no start", ctl_rdata[6], 1);
      chk("R9", "line idle", txck_o, 1);
      wr_ctl(8'h18); wait_idle();
      // R9 receive request blocks sync, not async
      rx_req = 1;
      wr_ctl(8'h18); wr_dat(8'h42); wait_idle();
      wr_ctl(8'h0B); wr_dat(8'h24);
      repeat (30) @(negedge clk);
      chk("R9", "rx_req hold", ctl_rdata[6], 1);
      rx_req = 0; wait_idle();
      // R6 master 8-bit and 9-bit
      cur_req = "R6";
      wr_ctl(8'h0B); wr_dat(8'h96); wait_idle();
      wr_ctl(8'h8F); wr_dat(8'h0F); wait_idle();
      // R4 high-speed bit has no effect in sync
      cur_req = "R4";
      wr_ctl(8'h1B); wr_dat(8'h6D); wait_idle();
      // R7 slave clock
      cur_req = "R7";
      wr_ctl(8'h09); slave_run = 1;
      wr_dat(8'hB2); wait_idle();
      wr_ctl(8'h8D); wr_dat(8'h4E); wait_idle();
      slave_run = 0;
      repeat (10) @(negedge clk);
      // R10 port disabled blocks start
      cur_req = "R10";
      port_en = 0;
      wr_ctl(8'h18); wr_dat(8'hE7);
      repeat (30) @(negedge clk);
      chk("R10", "no start", ctl_rdata[6], 1);
      port_en = 1; wait_idle();
      finish_run();
   end
endmodule